// File: doc/BRIEF.md
# Crest Factor Overcurrent Detector

This block guards a resonant half-bridge against inductor saturation. It watches a digitized stream of the voltage across the low-side switch while that switch conducts. The on-resistance turns this voltage into a stand-in for the switch current. The block compares each instantaneous sample with five times a slowly moving average of the same signal. A sample above that limit flags a crest-factor overcurrent. Because the limit follows the average and is not a fixed value, drift in on-resistance with temperature or with the choice of transistor cancels out.

The block forms a reference for each low-side conduction interval. A blanking window after each turn-on edge hides the ringing from switching. The first few samples taken after that window are averaged, and that mean is folded into an exponential moving average that spans many switching periods. Detection stays disarmed until the mode controller reports run mode for the first time. Comparisons are also suppressed while the average sits above a ceiling, because five times that average would lie beyond the sensing range. A fault appears as a single-clock pulse. The mode controller is expected to latch it and shut the bridge down.

Top module: `crest_factor_det`

## Requirements
- R1: During and directly after a synchronous reset, `crest_fault` and `avg_high` are 0, the average is 0 and detection is disarmed.
- R2: A sample is taken only in a cycle where `lo` and `smp_valid` are high, `lo_rise` is low, and at least BLANK_CYC cycles have passed since the `lo_rise` cycle. The `lo_rise` cycle counts as offset 0, so the first sample that can be taken is at offset BLANK_CYC. Samples at smaller offsets, and samples while `lo` is low, have no effect.
- R3: No fault is reported for a sample presented before the first cycle in which `run_en` is high. After that cycle, detection stays armed even when `run_en` falls.
- R4: A taken sample raises a fault when it is strictly greater than 5 × average. A sample equal to 5 × average does not.
- R5: Within each interval between `lo_rise` strobes, the first 2^MEAN_LOG2 taken samples are summed. At the next `lo_rise`, if all of them were collected, their mean (sum >> MEAN_LOG2) updates the average. An interval with fewer taken samples leaves the average unchanged.
- R6: The average is held as acc with EMA_LOG2 fraction bits. An update sets acc to acc − (acc >> EMA_LOG2) + mean, and the average is acc >> EMA_LOG2. A constant per-interval mean therefore drives the average to exactly that mean.
- R7: `avg_high` is 1 exactly while the average is greater than AVG_CEIL. While it is 1, no sample raises a fault.
- R8: `crest_fault` is high for one clock, in the cycle after the sample that caused it. It is high at most once per interval between `lo_rise` strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High once the mode controller has entered run mode; arms detection |
| lo | input | 1 | Low-side gate drive level |
| lo_rise | input | 1 | One-cycle strobe on the low-side turn-on edge; starts a new interval |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | SMP_W | Unsigned sample of the low-side switch voltage |
| crest_fault | output | 1 | One-cycle crest-factor fault pulse |
| avg_high | output | 1 | Average above the validity ceiling; comparisons suppressed |

## Verification
The bench first drives a fully sampled interval while disarmed, then arms and places single isolated spikes around the blanking edge and in the off phase. This separates the blanking and gating logic from the compare. Spikes of exactly 5× and 5×+1 the average are placed after partial intervals. These tell the strict comparison apart from a non-strict one, and show whether partial intervals wrongly update the average. A long run of constant-amplitude intervals brings the average to a known value, and this checks the moving-average arithmetic at the boundary. A flat interval that exceeds the limit on every sample shows that only one pulse is issued per interval. Raising and then lowering the steady level across the ceiling shows suppression switching on and off.

// File: rtl/cf_pkg.sv
package cf_pkg;

    // Default geometry of the detector
    localparam int unsigned CF_SMP_W     = 10;   // sample width
    localparam int unsigned CF_BLANK     = 50;   // blanking cycles (1 us at 50 MHz)
    localparam int unsigned CF_MEAN_LOG2 = 3;    // samples per interval mean = 2**n
    localparam int unsigned CF_EMA_LOG2  = 4;    // moving-average weight 1/2**n
    localparam int unsigned CF_CEIL      = 150;  // largest average still trusted

    // Per-cycle sample events produced by the blanking gate
    typedef struct packed {
        logic take;    // sample accepted for mean and compare
        logic close;   // interval boundary (turn-on strobe)
    } cf_evt_t;

    // Width needed to hold five times a value of width w
    function automatic int unsigned cf_x5_width(int unsigned w);
        return w + 3;
    endfunction

endpackage

// File: rtl/cf_blank_gate.sv
module cf_blank_gate
    import cf_pkg::*;
#(
    parameter int unsigned BLANK_CYC = CF_BLANK
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    lo,
    input  logic    lo_rise,
    input  logic    smp_valid,
    output cf_evt_t evt
);

    localparam int unsigned       CNT_W   = $clog2(BLANK_CYC + 1);
    localparam logic [CNT_W-1:0]  CNT_SAT = CNT_W'(BLANK_CYC);

    // Cycles since the turn-on strobe, saturating at the blanking length
    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (lo_rise) begin
            since_q <= CNT_W'(1);
        end else if (!lo) begin
            since_q <= '0;
        end else if (since_q != CNT_SAT) begin
            since_q <= since_q + CNT_W'(1);
        end
    end

    always_comb begin
        evt.close = lo_rise;
        evt.take  = lo && smp_valid && !lo_rise && (since_q == CNT_SAT);
    end

endmodule

// File: rtl/cf_cycle_mean.sv
module cf_cycle_mean
    import cf_pkg::*;
#(
    parameter int unsigned SMP_W     = CF_SMP_W,
    parameter int unsigned MEAN_LOG2 = CF_MEAN_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  cf_evt_t          evt,
    input  logic [SMP_W-1:0] smp_data,
    output logic             mean_vld,
    output logic [SMP_W-1:0] mean
);

    localparam int unsigned          SUM_W = SMP_W + MEAN_LOG2;
    localparam int unsigned          N_W   = MEAN_LOG2 + 1;
    localparam logic [N_W-1:0]       N_FULL = N_W'(1) << MEAN_LOG2;

    logic [SUM_W-1:0] sum_q;
    logic [N_W-1:0]   cnt_q;
    logic             full;

    assign full = (cnt_q == N_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (evt.close) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (evt.take && !full) begin
            sum_q <= sum_q + SUM_W'(smp_data);
            cnt_q <= cnt_q + N_W'(1);
        end
    end

    // Mean is offered only at the boundary and only for a full interval
    assign mean_vld = evt.close && full;
    assign mean     = sum_q[SUM_W-1:MEAN_LOG2];

endmodule

// File: rtl/cf_ema.sv
module cf_ema
    import cf_pkg::*;
#(
    parameter int unsigned SMP_W    = CF_SMP_W,
    parameter int unsigned EMA_LOG2 = CF_EMA_LOG2,
    parameter int unsigned AVG_CEIL = CF_CEIL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mean_vld,
    input  logic [SMP_W-1:0] mean,
    output logic [SMP_W-1:0] avg,
    output logic             avg_high
);

    localparam int unsigned ACC_W = SMP_W + EMA_LOG2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;

    // acc never exceeds (2**SMP_W-1) << EMA_LOG2, so modular arithmetic is exact
    assign acc_nx = acc_q - (acc_q >> EMA_LOG2) + ACC_W'(mean);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (mean_vld) begin
            acc_q <= acc_nx;
        end
    end

    assign avg      = acc_q[ACC_W-1:EMA_LOG2];
    assign avg_high = (32'(avg) > AVG_CEIL);

endmodule

// File: rtl/cf_fault_cmp.sv
module cf_fault_cmp
    import cf_pkg::*;
#(
    parameter int unsigned SMP_W = CF_SMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cf_evt_t          evt,
    input  logic [SMP_W-1:0] smp_data,
    input  logic [SMP_W-1:0] avg,
    input  logic             avg_high,
    input  logic             run_en,
    output logic             crest_fault
);

    localparam int unsigned P_W = cf_x5_width(SMP_W);

    logic [P_W-1:0] limit;
    logic           armed_q;
    logic           fired_q;
    logic           fault_q;
    logic           hit;

    // 5*avg as (avg << 2) + avg, widened so the sum cannot wrap
    assign limit = P_W'({avg, 2'b00}) + P_W'(avg);

    assign hit = evt.take && (armed_q || run_en) && !avg_high
                 && (P_W'(smp_data) > limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            fired_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            armed_q <= armed_q || run_en;
            fault_q <= hit && !fired_q;
            fired_q <= evt.close ? 1'b0 : (fired_q || hit);
        end
    end

    assign crest_fault = fault_q;

endmodule

// File: rtl/crest_factor_det.sv
module crest_factor_det
    import cf_pkg::*;
#(
    parameter int unsigned SMP_W     = CF_SMP_W,
    parameter int unsigned BLANK_CYC = CF_BLANK,
    parameter int unsigned MEAN_LOG2 = CF_MEAN_LOG2,
    parameter int unsigned EMA_LOG2  = CF_EMA_LOG2,
    parameter int unsigned AVG_CEIL  = CF_CEIL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             lo,
    input  logic             lo_rise,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             crest_fault,
    output logic             avg_high
);

    cf_evt_t          evt;
    logic             mean_vld;
    logic [SMP_W-1:0] mean;
    logic [SMP_W-1:0] avg;

    cf_blank_gate #(
        .BLANK_CYC (BLANK_CYC)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .lo        (lo),
        .lo_rise   (lo_rise),
        .smp_valid (smp_valid),
        .evt       (evt)
    );

    cf_cycle_mean #(
        .SMP_W     (SMP_W),
        .MEAN_LOG2 (MEAN_LOG2)
    ) u_mean (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .smp_data (smp_data),
        .mean_vld (mean_vld),
        .mean     (mean)
    );

    cf_ema #(
        .SMP_W    (SMP_W),
        .EMA_LOG2 (EMA_LOG2),
        .AVG_CEIL (AVG_CEIL)
    ) u_ema (
        .clk      (clk),
        .rst      (rst),
        .mean_vld (mean_vld),
        .mean     (mean),
        .avg      (avg),
        .avg_high (avg_high)
    );

    cf_fault_cmp #(
        .SMP_W (SMP_W)
    ) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .smp_data    (smp_data),
        .avg         (avg),
        .avg_high    (avg_high),
        .run_en      (run_en),
        .crest_fault (crest_fault)
    );

endmodule

// File: rtl/cf_checker.sv
module cf_checker #(
    parameter int unsigned BLANK_CYC = 50
) (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic lo,
    input logic lo_rise,
    input logic smp_valid,
    input logic crest_fault,
    input logic avg_high
);

    localparam int unsigned CK_W = $clog2(BLANK_CYC + 1);

    logic [CK_W-1:0] ck_since;
    logic            ck_open;   // previous cycle could legally sample
    logic            ck_seen;   // run_en observed up to previous cycle

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_since <= '0;
            ck_open  <= 1'b0;
            ck_seen  <= 1'b0;
        end else begin
            ck_open  <= lo && smp_valid && !lo_rise && (32'(ck_since) >= BLANK_CYC);
            ck_seen  <= ck_seen || run_en;
            if (lo_rise)
                ck_since <= CK_W'(1);
            else if (!lo)
                ck_since <= '0;
            else if (32'(ck_since) < BLANK_CYC)
                ck_since <= ck_since + CK_W'(1);
        end
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!crest_fault && !avg_high));

    // R2: a fault only follows a sample outside blanking, with lo high
    a_r2_blanked: assert property (@(posedge clk) disable iff (rst)
        crest_fault |-> ck_open);

    // R3: no fault before run mode has been seen
    a_r3_armed: assert property (@(posedge clk) disable iff (rst)
        crest_fault |-> ck_seen);

    // R7: no fault from a compare made while the average was above ceiling
    a_r7_ceiling: assert property (@(posedge clk) disable iff (rst)
        crest_fault |-> !$past(avg_high));

    // R8: fault is a single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        crest_fault |=> !crest_fault);

endmodule

bind crest_factor_det cf_checker #(
    .BLANK_CYC (BLANK_CYC)
) u_cf_checker (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .lo          (lo),
    .lo_rise     (lo_rise),
    .smp_valid   (smp_valid),
    .crest_fault (crest_fault),
    .avg_high    (avg_high)
);

// File: tb/tb_crest_factor_det.sv
module tb_crest_factor_det;

    localparam int W    = 10;
    localparam int B    = 50;
    localparam int ML   = 3;
    localparam int EL   = 4;
    localparam int CEIL = 150;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         run_en = 1'b0;
    logic         lo = 1'b0;
    logic         lo_rise = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic         crest_fault;
    logic         avg_high;

    always #10 clk = ~clk;   // 50 MHz

    crest_factor_det dut (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .lo          (lo),
        .lo_rise     (lo_rise),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .crest_fault (crest_fault),
        .avg_high    (avg_high)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    pulses = 0;
    string tag = "R1";
    bit    done = 0;

    // Behavioural reference, evaluated on each rising edge
    int m_armed, m_cnt, m_sum, m_n, m_acc, m_fired;
    bit m_fault, m_high;

    always @(posedge clk) begin
        int avg_now;
        bit take, hit;
        if (rst) begin
            m_armed = 0; m_cnt = 0; m_sum = 0; m_n = 0;
            m_acc = 0; m_fired = 0; m_fault = 0; m_high = 0;
        end else begin
            avg_now = m_acc >> EL;
            take    = smp_valid && lo && !lo_rise && (m_cnt >= B);
            hit     = take && (m_armed != 0 || run_en) && !(avg_now > CEIL)
                      && (int'(smp_data) > 5 * avg_now);
            m_fault = hit && (m_fired == 0);
            m_fired = lo_rise ? 0 : ((m_fired != 0 || hit) ? 1 : 0);
            if (lo_rise) begin
                if (m_n == (1 << ML))
                    m_acc = m_acc - (m_acc >> EL) + (m_sum >> ML);
                m_sum = 0;
                m_n   = 0;
            end else if (take && m_n < (1 << ML)) begin
                m_sum = m_sum + int'(smp_data);
                m_n   = m_n + 1;
            end
            if (lo_rise)      m_cnt = 1;
            else if (!lo)     m_cnt = 0;
            else if (m_cnt < B) m_cnt = m_cnt + 1;
            if (run_en) m_armed = 1;
            m_high = (m_acc >> EL) > CEIL;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock: compare against the model at the falling edge, then drive
    task automatic step(input bit l, input bit r, input bit v, input int d, input bit ren);
        @(negedge clk);
        chk({tag, " crest_fault vs model"}, int'(crest_fault), int'(m_fault));
        chk({tag, " avg_high vs model"}, int'(avg_high), int'(m_high));
        if (crest_fault) pulses++;
        lo        = l;
        lo_rise   = r;
        smp_valid = v;
        smp_data  = W'(d);
        run_en    = ren;
    endtask

    // One switching interval: hi cycles of lo high, lo_len low; optional spike
    task automatic lo_cycle(input int hi, input int lo_len, input bit bv,
                            input int bval, input int soff, input int sval);
        pulses = 0;
        for (int k = 0; k < hi + lo_len; k++) begin
            bit l  = (k < hi);
            bit sp = (k == soff);
            step(l, k == 0, (bv && l) || sp, sp ? sval : bval, 1'b0);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) step(1'b0, 1'b0, 1'b0, 0, 1'b0);
        chk("R1 crest_fault after reset", int'(crest_fault), 0);
        chk("R1 avg_high after reset", int'(avg_high), 0);
        rst = 1'b0;

        // R3: full interval of 16s while disarmed, average 0 -> no fault
        tag = "R3";
        lo_cycle(60, 10, 1'b1, 16, -1, 0);
        chk("R3 no fault while disarmed", pulses, 0);
        // Arm with a single-cycle run_en; it must stay armed
        step(1'b0, 1'b0, 1'b0, 0, 1'b1);

        // R2: average now 1, limit 5; spike 6 at blanking edges
        tag = "R2";
        lo_cycle(60, 10, 1'b0, 0, B - 1, 6);
        chk("R2 spike one cycle inside blanking ignored", pulses, 0);
        lo_cycle(60, 10, 1'b0, 0, B, 6);
        chk("R2 spike at first open cycle detected (R3 stays armed)", pulses, 1);
        lo_cycle(60, 10, 1'b0, 0, 62, 6);
        chk("R2 spike while lo low ignored", pulses, 0);

        // R4 / R5: average held at 1 across partial intervals
        tag = "R4";
        lo_cycle(60, 10, 1'b0, 0, 55, 5);
        chk("R4 sample equal to 5x average no fault", pulses, 0);
        tag = "R5";
        lo_cycle(60, 10, 1'b0, 0, 55, 6);
        chk("R5 partial intervals keep average, 6 > 5 faults", pulses, 1);

        // R8: every sample over the limit, only one pulse
        tag = "R8";
        lo_cycle(60, 10, 1'b1, 100, -1, 0);
        chk("R8 one pulse per interval", pulses, 1);

        // R6: settle on constant mean 80, probe limit 400
        tag = "R6";
        for (int i = 0; i < 130; i++) lo_cycle(60, 10, 1'b1, 80, -1, 0);
        lo_cycle(60, 10, 1'b0, 0, 55, 400);
        chk("R6 settled average 80, 400 not over limit", pulses, 0);
        lo_cycle(60, 10, 1'b0, 0, 55, 401);
        chk("R6 settled average 80, 401 over limit", pulses, 1);

        // R7: average above ceiling suppresses, then below re-enables
        tag = "R7";
        for (int i = 0; i < 80; i++) lo_cycle(60, 10, 1'b1, 160, -1, 0);
        lo_cycle(60, 10, 1'b0, 0, 55, 1000);
        chk("R7 avg_high set above ceiling", int'(avg_high), 1);
        chk("R7 no fault while above ceiling", pulses, 0);
        for (int i = 0; i < 80; i++) lo_cycle(60, 10, 1'b1, 100, -1, 0);
        lo_cycle(60, 10, 1'b0, 0, 55, 1000);
        chk("R7 avg_high cleared below ceiling", int'(avg_high), 0);
        chk("R7 fault restored below ceiling", pulses, 1);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule